// File: doc/BRIEF.md
# Multi-Mode Phase-Accumulator Oscillator Core

This block is the numeric heart of a direct digital synthesizer. A 32-bit phase accumulator advances by a frequency tuning word on every clock. The top 16 bits of the accumulator, plus a 16-bit phase offset, form the output phase word. A downstream sine lookup consumes that word together with a 12-bit amplitude word. The lookup table, the DAC and the host interface all sit outside this block.

The host loads new tuning, offset, amplitude and phase-mode values into a staging bank whenever it likes. None of those values touches the running oscillator until a one-cycle update strobe arrives. At that strobe all staged values become active together. The staged mode decides what happens to the accumulator at that edge:

- **keep:** the accumulator carries on.
- **clear:** the accumulator is zeroed, so the output phase equals the offset.
- **track:** the accumulator is loaded with the phase it would hold had it run at the new tuning word since reset.

Track mode relies on a free-running 64-bit cycle counter held inside the block.

Top module: `nco_core`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: phase_out is 0 and amp_out is 0xFFF (full scale). The accumulator, the cycle counter and all staged and active settings are cleared; both amplitude registers are set to 0xFFF and both modes to keep (code 0).
- R2: On every clock edge out of reset, the accumulator advances by the active tuning word, modulo 2^32. phase_out equals (accumulator bits 31:16 + active phase offset) modulo 2^16, for the accumulator value after the same edge.
- R3: A write with stage_we high changes only the staging bank. Without an update strobe, phase_out and amp_out continue exactly as before.
- R4: An update strobe copies the staged tuning word, phase offset and amplitude into the active set together. The new values are seen on phase_out and amp_out right after the edge that samples the strobe (one-cycle latency).
- R5: Keep mode is mode code 0; code 3 behaves the same. At an update in keep mode, the accumulator takes its normal step with the previously active tuning word, so only a change of offset makes the phase jump.
- R6: Clear mode is mode code 1. At an update in clear mode the accumulator becomes 0, so phase_out right after the update equals the new phase offset.
- R7: Track mode is mode code 2. At an update in track mode the accumulator becomes (new tuning word × N) mod 2^32. N is the cycle counter value after that edge.
- R8: The cycle counter is 0 in reset and increases by one on every clock edge out of reset. The first edge with rst_n high therefore gives N = 1.
- R9: When stage_we and update are high in the same cycle, the update applies the staging bank as it stood before that edge. The new write is held for the next update.
- R10: amp_out always equals the active amplitude word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_we | input | 1 | Writes the four staging inputs into the staging bank |
| stage_ftw | input | 32 | Tuning word to stage |
| stage_pow | input | 16 | Phase offset to stage |
| stage_asf | input | 12 | Amplitude word to stage |
| stage_mode | input | 2 | Phase mode to stage: 0 keep, 1 clear, 2 track, 3 keep |
| update | input | 1 | Update strobe; makes the staged set active |
| phase_out | output | 16 | Registered phase word for the lookup |
| amp_out | output | 12 | Registered amplitude word |

## Verification
The embedded properties watch, on every cycle:

- the counter's unit step;
- the accumulator's plain advance when no update arrives, and in keep mode;
- the zeroing in clear mode;
- the tracking load against the counter;
- the stability of the active set between updates;
- the use of old staged values under a simultaneous write.

The bench's scenarios alone show the values seen at the ports. These are the phase sum with the offset and its wrap, the amplitude path, and the one-cycle latency. They also cover long random mixes of stage writes, updates and modes against an independent cycle model, and the directed reset and collision cases.

// File: rtl/nco_pkg.sv
// Shared definitions for the oscillator core.
// Assumes: mode codes are fixed by the host-side encoding (0 keep, 1 clear,
// 2 track, 3 reserved and treated as keep).
package nco_pkg;

    typedef enum logic [1:0] {
        PM_KEEP  = 2'd0,
        PM_CLEAR = 2'd1,
        PM_TRACK = 2'd2,
        PM_RSVD  = 2'd3
    } phase_mode_e;

endpackage

// File: rtl/nco_time_base.sv
// Free-running cycle counter used as the global time origin.
// Assumes: CNT_W >= OUT_W; only the low OUT_W bits leave the module, since
// tracking works modulo 2^OUT_W.
module nco_time_base #(
    parameter int CNT_W = 64,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] scale_next,
    output logic [OUT_W-1:0] scale_now
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // next count: one more cycle since reset
    always_comb cnt_nx = cnt_q + CNT_W'(1);

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

    assign scale_next = cnt_nx[OUT_W-1:0];
    assign scale_now  = cnt_q[OUT_W-1:0];

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/nco_shadow.sv
// Staging bank and active settings.
// Staging writes land at any edge. The update strobe copies the pre-edge
// staging contents into the active set.
// Assumes: a write and an update in the same cycle apply the old staged values.
module nco_shadow
    import nco_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int POW_W = 16,
    parameter int ASF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage_we,
    input  logic [FTW_W-1:0] ftw_in,
    input  logic [POW_W-1:0] pow_in,
    input  logic [ASF_W-1:0] asf_in,
    input  phase_mode_e      mode_in,
    input  logic             update,
    output logic [FTW_W-1:0] stg_ftw,
    output phase_mode_e      stg_mode,
    output logic [FTW_W-1:0] act_ftw,
    output logic [POW_W-1:0] pow_nx,
    output logic [ASF_W-1:0] asf_nx
);

    localparam logic [ASF_W-1:0] ASF_FULL = {ASF_W{1'b1}};

    logic [POW_W-1:0] stg_pow;
    logic [ASF_W-1:0] stg_asf;
    logic [POW_W-1:0] act_pow;
    logic [ASF_W-1:0] act_asf;

    // staging bank write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ftw  <= '0;
            stg_pow  <= '0;
            stg_asf  <= ASF_FULL;
            stg_mode <= PM_KEEP;
        end else if (stage_we) begin
            stg_ftw  <= ftw_in;
            stg_pow  <= pow_in;
            stg_asf  <= asf_in;
            stg_mode <= mode_in;
        end
    end

    // next active offset and amplitude, shared with the output stage
    always_comb begin
        pow_nx = update ? stg_pow : act_pow;
        asf_nx = update ? stg_asf : act_asf;
    end

    // active set transfer on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ftw <= '0;
            act_pow <= '0;
            act_asf <= ASF_FULL;
        end else begin
            if (update) act_ftw <= stg_ftw;
            act_pow <= pow_nx;
            act_asf <= asf_nx;
        end
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(act_ftw) && $stable(act_pow) && $stable(act_asf));

    // R9
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update && stage_we |=> act_ftw == $past(stg_ftw) && stg_ftw == $past(ftw_in));

endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator with three behaviours at the update strobe.
// Assumes: the mode and tuning word of an update come from the staging bank;
// trk_scale is the cycle count that will hold after this edge.
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int FTW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update,
    input  phase_mode_e      mode,
    input  logic [FTW_W-1:0] stg_ftw,
    input  logic [FTW_W-1:0] act_ftw,
    input  logic [FTW_W-1:0] trk_scale,
    output logic [FTW_W-1:0] acc_q,
    output logic [FTW_W-1:0] acc_nx
);

    logic [FTW_W-1:0] acc_step;
    logic [FTW_W-1:0] acc_trk;

    // free-running step and tracking target
    always_comb begin
        acc_step = acc_q + act_ftw;
        acc_trk  = stg_ftw * trk_scale;
    end

    // select the next accumulator value
    always_comb begin
        acc_nx = acc_step;
        if (update) begin
            unique case (mode)
                PM_CLEAR: acc_nx = '0;
                PM_TRACK: acc_nx = acc_trk;
                default:  acc_nx = acc_step;
            endcase
        end
    end

    // accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_nx;
    end

    // R5
    keep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update || mode == PM_KEEP || mode == PM_RSVD)
        |=> acc_q == $past(acc_q) + $past(act_ftw));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update && mode == PM_CLEAR |=> acc_q == '0);

endmodule

// File: rtl/nco_core.sv
// Oscillator core top: staging bank, cycle counter, accumulator and the
// registered phase and amplitude outputs.
// Assumes: the update strobe is one clock wide per intended update; the
// outputs show the new settings one edge after the strobe is sampled.
module nco_core
    import nco_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int POW_W = 16,
    parameter int ASF_W = 12,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage_we,
    input  logic [31:0]      stage_ftw,
    input  logic [15:0]      stage_pow,
    input  logic [11:0]      stage_asf,
    input  logic [1:0]       stage_mode,
    input  logic             update,
    output logic [15:0]      phase_out,
    output logic [11:0]      amp_out
);

    localparam logic [ASF_W-1:0] ASF_FULL = {ASF_W{1'b1}};

    logic [FTW_W-1:0] stg_ftw;
    logic [FTW_W-1:0] act_ftw;
    logic [POW_W-1:0] pow_nx;
    logic [ASF_W-1:0] asf_nx;
    logic [FTW_W-1:0] acc_q;
    logic [FTW_W-1:0] acc_nx;
    logic [FTW_W-1:0] scale_next;
    logic [FTW_W-1:0] scale_now;
    phase_mode_e      stg_mode;
    phase_mode_e      mode_in;

    // map raw mode bits onto the enum
    always_comb mode_in = phase_mode_e'(stage_mode);

    nco_time_base #(.CNT_W(CNT_W), .OUT_W(FTW_W)) time_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scale_next (scale_next),
        .scale_now  (scale_now)
    );

    nco_shadow #(.FTW_W(FTW_W), .POW_W(POW_W), .ASF_W(ASF_W)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_we (stage_we),
        .ftw_in   (stage_ftw),
        .pow_in   (stage_pow),
        .asf_in   (stage_asf),
        .mode_in  (mode_in),
        .update   (update),
        .stg_ftw  (stg_ftw),
        .stg_mode (stg_mode),
        .act_ftw  (act_ftw),
        .pow_nx   (pow_nx),
        .asf_nx   (asf_nx)
    );

    nco_phase_acc #(.FTW_W(FTW_W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .update    (update),
        .mode      (stg_mode),
        .stg_ftw   (stg_ftw),
        .act_ftw   (act_ftw),
        .trk_scale (scale_next),
        .acc_q     (acc_q),
        .acc_nx    (acc_nx)
    );

    // output register: phase sum and amplitude
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out <= '0;
            amp_out   <= ASF_FULL;
        end else begin
            phase_out <= acc_nx[FTW_W-1 -: POW_W] + pow_nx;
            amp_out   <= asf_nx;
        end
    end

    // R7
    track_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update && stg_mode == PM_TRACK |=> acc_q == $past(stg_ftw) * scale_now);

    // R2
    phase_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> phase_out - acc_q[FTW_W-1 -: POW_W] == $past(phase_out - acc_q[FTW_W-1 -: POW_W]));

endmodule

// File: tb/nco_core_tb.sv
module nco_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stage_we;
    logic [31:0] stage_ftw;
    logic [15:0] stage_pow;
    logic [11:0] stage_asf;
    logic [1:0]  stage_mode;
    logic        update;
    logic [15:0] phase_out;
    logic [11:0] amp_out;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [63:0] m_cnt;
    logic [31:0] m_acc;
    logic [31:0] m_sftw, m_aftw;
    logic [15:0] m_spow, m_apow;
    logic [11:0] m_sasf, m_aasf;
    logic [1:0]  m_smode;
    logic [15:0] e_phase;
    logic [11:0] e_amp;

    always #4 clk = ~clk;

    nco_core dut_i (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_ftw(stage_ftw),
        .stage_pow(stage_pow), .stage_asf(stage_asf), .stage_mode(stage_mode),
        .update(update), .phase_out(phase_out), .amp_out(amp_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // model one edge with the inputs currently driven
    task automatic model_edge();
        logic [63:0] cn;
        if (!rst_n) begin
            m_cnt = '0; m_acc = '0;
            m_sftw = '0; m_aftw = '0; m_spow = '0; m_apow = '0;
            m_sasf = 12'hFFF; m_aasf = 12'hFFF; m_smode = 2'd0;
        end else begin
            cn = m_cnt + 64'd1;
            if (update) begin
                if (m_smode == 2'd1)      m_acc = '0;
                else if (m_smode == 2'd2) m_acc = m_sftw * cn[31:0];
                else                      m_acc = m_acc + m_aftw;
                m_aftw = m_sftw; m_apow = m_spow; m_aasf = m_sasf;
            end else begin
                m_acc = m_acc + m_aftw;
            end
            m_cnt = cn;
            if (stage_we) begin
                m_sftw = stage_ftw; m_spow = stage_pow;
                m_sasf = stage_asf; m_smode = stage_mode;
            end
        end
        e_phase = m_acc[31:16] + m_apow;
        e_amp   = m_aasf;
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, 32'(phase_out), 32'(e_phase));
        check("R10 amp", 32'(amp_out), 32'(e_amp));
        stage_we = 1'b0;
        update   = 1'b0;
    endtask

    task automatic stage(input logic [31:0] f, input logic [15:0] p,
                         input logic [11:0] a, input logic [1:0] m);
        stage_we = 1'b1; stage_ftw = f; stage_pow = p; stage_asf = a; stage_mode = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; stage_we = 1'b0; update = 1'b0;
        stage_ftw = '0; stage_pow = '0; stage_asf = '0; stage_mode = '0;
        step("R1 reset");
        step("R1 reset");
        check("R1 phase", 32'(phase_out), 32'h0);
        check("R1 amp", 32'(amp_out), 32'hFFF);
        rst_n = 1'b1;

        // R3: staged values are invisible without update
        stage(32'h0001_0000, 16'h1234, 12'h456, 2'd0);
        step("R3 stage only");
        for (int i = 0; i < 4; i++) step("R3 idle");
        check("R3 phase held", 32'(phase_out), 32'h0);

        // R4: update applies everything together, one cycle later
        update = 1'b1;
        step("R4 update");
        check("R4 amp", 32'(amp_out), 32'h456);
        check("R4 phase", 32'(phase_out), 32'h1234);

        // R2: phase advances by one top-count per cycle
        for (int i = 0; i < 6; i++) step("R2 advance");
        check("R2 run", 32'(phase_out), 32'h123A);

        // R5: keep mode with a new tuning word, codes 0 and 3
        stage(32'h0100_0000, 16'h0000, 12'h7FF, 2'd3);
        step("R5 stage");
        update = 1'b1;
        step("R5 keep code3");
        for (int i = 0; i < 3; i++) step("R5 after");

        // R6: clear mode
        stage(32'h0200_0000, 16'hABCD, 12'h111, 2'd1);
        step("R6 stage");
        update = 1'b1;
        step("R6 clear");
        check("R6 phase equals offset", 32'(phase_out), 32'hABCD);

        // R7 / R8: tracking after a long run
        for (int i = 0; i < 500; i++) step("R8 run");
        stage(32'h0003_7001, 16'h0000, 12'hFFF, 2'd2);
        step("R7 stage");
        update = 1'b1;
        step("R7 track");
        for (int i = 0; i < 3; i++) step("R7 after");

        // R9: write and update in the same cycle
        stage(32'h0000_8000, 16'h0F00, 12'h0AA, 2'd1);
        step("R9 stage A");
        stage(32'hDEAD_BEEF, 16'h5555, 12'h333, 2'd0);
        update = 1'b1;
        step("R9 collide");
        check("R9 old values", 32'(amp_out), 32'h0AA);
        update = 1'b1;
        step("R9 second update");
        check("R9 new values", 32'(amp_out), 32'h333);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            string tg;
            if ($urandom_range(0, 2) == 0)
                stage($urandom, 16'($urandom), 12'($urandom), 2'($urandom_range(0, 3)));
            update = ($urandom_range(0, 7) == 0);
            tg = "R2 random";
            if (update && m_smode == 2'd1) tg = "R6 random";
            if (update && m_smode == 2'd2) tg = "R7 random";
            if (update && (m_smode == 2'd0 || m_smode == 2'd3)) tg = "R5 random";
            step(tg);
        end

        // reset again mid-run
        rst_n = 1'b0;
        step("R1 re-reset");
        rst_n = 1'b1;
        stage(32'h0001_0000, 16'h0000, 12'h001, 2'd2);
        step("R8 after reset");
        update = 1'b1;
        step("R8 track count restarts");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule